// File: doc/BRIEF.md
# Nibble-Serial LCD Line Scanner

This block drives a monochrome LCD panel that takes pixels four at a time. Each display line is 640 pixels wide. At the start of a line slot the block shifts the whole line out of a 640-bit shift register as 160 nibbles. A data shift clock runs only while those nibbles are sent. The rest of the slot is quiet. The block also makes a short line pulse when each burst ends, and a frame signal that marks the first line of every frame.

While the current line is quiet, the block reads the 80 bytes for the next line from memory. It uses a simple request/acknowledge read port, one byte per accepted beat. The read address is a base address plus the line number times 80 plus the byte index. When the enable input is low the block stops scanning, clears its state and holds every output low.

One clock cycle is half a pixel-clock period. A nibble therefore occupies two cycles. With a 6.5536 MHz clock, the nibble rate is 3.2768 MHz, a line slot is 156.25 µs and a 64-line frame is 10 ms.

Top module: `lcd_line_scanner`

## Requirements
- R1: While `en` is low, `ld`, `sclk`, `lp`, `fr` and `rd_req` are all 0, and the effect is immediate. The counters and the shift register are cleared, so raising `en` starts line 0 at slot cycle 0.
- R2: A line slot lasts 1024 clock cycles (512 pixel-clock periods). A frame lasts 64 slots. After line 63 the line number returns to 0.
- R3: Nibble k (0 to 159) of a line is on `ld` during slot cycles 2k and 2k+1. `ld` is 0 in slot cycles 320 to 1023.
- R4: During the burst, `sclk` is 0 on even slot cycles and 1 on odd slot cycles. `sclk` is 0 throughout the idle part of the slot.
- R5: Byte j of a line, read from address base + line×80 + j, supplies nibble 2j from bits 7:4 and nibble 2j+1 from bits 3:0.
- R6: `lp` is 1 in slot cycles 320 and 321 of every slot, and 0 in all other cycles.
- R7: `fr` is 1 for the whole slot of line 0 and 0 during lines 1 to 63.
- R8: `rd_req` rises at slot cycle 320. It stays high until 80 bytes have been accepted, and it is never high during the burst. A byte is accepted in a cycle where `rd_req` and `rd_ack` are both 1. While `rd_req` is high, `rd_addr` = base + ((line+1) mod 64)×80 + (number of bytes accepted so far in this slot).
- R9: The first line slot after `en` rises sends only zero nibbles, because no data has been fetched for it yet.
- R10: While a request waits without `rd_ack`, `rd_addr` does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, two cycles per pixel-clock period |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Display on; low stops scanning and clears state |
| base_addr | input | 16 | Byte address of line 0 |
| rd_req | output | 1 | Memory read request |
| rd_addr | output | 16 | Memory read byte address |
| rd_ack | input | 1 | Read accepted; `rd_data` is valid in this cycle |
| rd_data | input | 8 | Read byte |
| ld | output | 4 | Panel data nibble |
| sclk | output | 1 | Panel data shift clock |
| lp | output | 1 | End-of-burst line pulse |
| fr | output | 1 | Frame marker, high during line 0 |

## Verification
All outputs are decoded from registered state, so `ld`, `sclk`, `lp`, `fr` and `rd_req` describe slot cycle n in the same cycle that the slot counter reaches n. An accepted byte moves `rd_addr` forward one cycle later. The bench counts clock edges from the moment `en` rises and samples on every falling edge, where the edge count is the slot cycle. It therefore predicts every output from that count together with its own tally of acknowledges it has granted. Dropping `en` is checked shortly after the change, with no clock edge in between, because the outputs go quiet without waiting for a register.

// File: rtl/lcd_line_scanner.sv
module lcd_line_scanner #(
  parameter int LINE_BITS = 640,
  parameter int NIB_W     = 4,
  parameter int BYTE_W    = 8,
  parameter int SLOT_PIX  = 512,
  parameter int LINES     = 64,
  parameter int ADDR_W    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [ADDR_W-1:0] base_addr,
  output logic              rd_req,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic              rd_ack,
  input  logic [BYTE_W-1:0] rd_data,
  output logic [NIB_W-1:0]  ld,
  output logic              sclk,
  output logic              lp,
  output logic              fr
);
  localparam int NIBS     = LINE_BITS / NIB_W;
  localparam int BYTES    = LINE_BITS / BYTE_W;
  localparam int SLOT_CYC = 2 * SLOT_PIX;
  localparam int BURST    = 2 * NIBS;
  localparam int POS_W    = $clog2(SLOT_CYC);
  localparam int LINE_W   = $clog2(LINES);
  localparam int FCNT_W   = $clog2(BYTES + 1);

  localparam logic [POS_W-1:0]  BURST_END = POS_W'(BURST);
  localparam logic [POS_W-1:0]  LP_END    = POS_W'(BURST + 2);
  localparam logic [POS_W-1:0]  POS_LAST  = POS_W'(SLOT_CYC - 1);
  localparam logic [LINE_W-1:0] LINE_LAST = LINE_W'(LINES - 1);
  localparam logic [FCNT_W-1:0] FCNT_ALL  = FCNT_W'(BYTES);

  logic [POS_W-1:0]     pos;
  logic [LINE_W-1:0]    line;
  logic [FCNT_W-1:0]    fcnt;
  logic [LINE_BITS-1:0] sr;

  logic [LINE_W-1:0] nxt_line;
  logic in_burst, last_pos, take;

  assign nxt_line = (line == LINE_LAST) ? '0 : line + 1'b1;
  assign last_pos = (pos == POS_LAST);
  assign in_burst = en && (pos < BURST_END);
  assign rd_req   = en && !in_burst && (fcnt < FCNT_ALL);
  assign take     = rd_req && rd_ack;
  assign rd_addr  = base_addr + ADDR_W'(nxt_line) * ADDR_W'(BYTES) + ADDR_W'(fcnt);

  assign ld   = in_burst ? sr[LINE_BITS-1 -: NIB_W] : '0;
  assign sclk = in_burst && pos[0];
  assign lp   = en && (pos >= BURST_END) && (pos < LP_END);
  assign fr   = en && (line == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos  <= '0;
      line <= '0;
      fcnt <= '0;
      sr   <= '0;
    end else if (!en) begin
      pos  <= '0;
      line <= '0;
      fcnt <= '0;
      sr   <= '0;
    end else begin
      pos <= last_pos ? '0 : pos + 1'b1;
      if (last_pos) line <= nxt_line;
      if (last_pos)  fcnt <= '0;
      else if (take) fcnt <= fcnt + 1'b1;
      if (take)
        sr <= {sr[LINE_BITS-BYTE_W-1:0], rd_data};
      else if (in_burst && pos[0])
        sr <= {sr[LINE_BITS-NIB_W-1:0], {NIB_W{1'b0}}};
    end
  end
endmodule

module lcd_line_scanner_chk #(
  parameter int NIB_W  = 4,
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              en,
  input logic              rd_req,
  input logic              rd_ack,
  input logic [ADDR_W-1:0] rd_addr,
  input logic [NIB_W-1:0]  ld,
  input logic              sclk,
  input logic              lp,
  input logic              fr
);
  AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> (ld == '0 && !sclk && !lp && !fr && !rd_req)); // R1
  AST_IDLE_AT_LP: assert property (@(posedge clk) disable iff (!rst_n)
    lp |-> (ld == '0 && !sclk)); // R3
  AST_SCLK_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n || !en)
    sclk |=> !sclk); // R4
  AST_LP_TWO_CYCLES: assert property (@(posedge clk) disable iff (!rst_n || !en)
    $rose(lp) |=> lp ##1 !lp); // R6
  AST_NO_REQ_IN_BURST: assert property (@(posedge clk) disable iff (!rst_n)
    sclk |-> !rd_req); // R8
  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n || !en)
    (rd_req && !rd_ack) |=> (!rd_req || $stable(rd_addr))); // R10
endmodule

bind lcd_line_scanner lcd_line_scanner_chk #(.NIB_W(NIB_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .rd_req(rd_req), .rd_ack(rd_ack),
  .rd_addr(rd_addr), .ld(ld), .sclk(sclk), .lp(lp), .fr(fr)
);

// File: tb/test_lcd_line_scanner.sv
`timescale 1ns/1ps
module test_lcd_line_scanner;
  localparam int SLOT  = 1024;
  localparam int BURST = 320;
  localparam int LINES = 64;
  localparam int BYTES = 80;
  localparam logic [15:0] BASE = 16'h1230;

  logic clk = 1'b0, rst_n = 1'b0, en = 1'b0, rd_ack = 1'b0;
  logic [7:0] rd_data = '0;
  logic rd_req, sclk, lp, fr;
  logic [15:0] rd_addr;
  logic [3:0] ld;

  int nchk = 0, nfail = 0;
  int cyc = 0, nacc = 0, waitc = 0, lat = 0;

  always #2 clk = ~clk;

  lcd_line_scanner i_lcd_line_scanner (
    .clk(clk), .rst_n(rst_n), .en(en), .base_addr(BASE),
    .rd_req(rd_req), .rd_addr(rd_addr), .rd_ack(rd_ack), .rd_data(rd_data),
    .ld(ld), .sclk(sclk), .lp(lp), .fr(fr)
  );

  function automatic logic [7:0] mem(input logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'hA5;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s at cycle %0d: actual %0h expected %0h", tag, cyc, act, exp);
    end
  endtask

  task automatic chk_quiet(input string tag);
    chk(tag, ld, 0);
    chk(tag, sclk, 0);
    chk(tag, lp, 0);
    chk(tag, fr, 0);
    chk(tag, rd_req, 0);
  endtask

  task automatic start_scan();
    en = 1'b1;
    cyc = 0; nacc = 0; waitc = 0; lat = 0;
  endtask

  task automatic step();
    @(negedge clk);
    if (!en) begin
      chk_quiet("R1");
      rd_ack = 1'b0;
    end else begin
      int s, p, L, k, exp_ld;
      logic [7:0] b;
      cyc++;
      s = cyc / SLOT; p = cyc % SLOT; L = s % LINES;
      if (p == 0) begin nacc = 0; waitc = 0; lat = s % 4; end
      if (p < BURST) begin
        k = p / 2;
        if (s == 0) exp_ld = 0;
        else begin
          b = mem(BASE + 16'(L * BYTES + k / 2));
          exp_ld = (k % 2 == 0) ? int'(b[7:4]) : int'(b[3:0]);
        end
        chk((s == 0) ? "R9" : "R5", ld, exp_ld);
      end else chk("R3", ld, 0);
      chk("R4", sclk, (p < BURST && p % 2 == 1) ? 1 : 0);
      chk("R6", lp, (p == BURST || p == BURST + 1) ? 1 : 0);
      chk((s >= LINES) ? "R2" : "R7", fr, (L == 0) ? 1 : 0);
      chk("R8", rd_req, (p >= BURST && nacc < BYTES) ? 1 : 0);
      if (rd_req)
        chk((waitc > 0) ? "R10" : "R8", rd_addr,
            int'(BASE + 16'(((L + 1) % LINES) * BYTES + nacc)));
      if (rd_req && waitc >= lat) begin
        rd_ack = 1'b1; rd_data = mem(rd_addr); nacc++; waitc = 0;
      end else begin
        rd_ack = 1'b0;
        if (rd_req) waitc++;
      end
    end
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk_quiet("R1");
    rst_n = 1'b1;
    step();
  endtask

  task automatic t_off();
    repeat (50) step();
  endtask

  task automatic t_frame();
    start_scan();
    repeat (65 * SLOT + 400) step();
  endtask

  task automatic t_stop();
    en = 1'b0; rd_ack = 1'b0;
    #1 chk_quiet("R1");
    repeat (20) step();
    start_scan();
    while (cyc < 2 * SLOT + 150) step();
    chk("R5", (ld != 0) ? 1 : 0, 1);
    en = 1'b0; rd_ack = 1'b0;
    #1 chk_quiet("R1");
    repeat (5) step();
    start_scan();
    repeat (10) step();
  endtask

  initial begin
    t_reset();
    t_off();
    t_frame();
    t_stop();
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    nfail++; nchk++;
    $display("FAIL watchdog: run did not complete, all requirements unchecked");
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule